// File: doc/BRIEF.md
# Controller Command and Status Unit

This block is the host-facing control point of a network controller. The host places a 16-bit command word on `host_cmd` and pulses `chan_attn`. The block then decodes two separate operation fields. One field drives the command unit, which executes the transmit-side action list. The other drives the receive unit. The block keeps the state of each unit and latches four interrupt causes. It presents all of this in a 16-bit status word.

The engines that walk the action list and the receive area are outside this block. They report events through single-cycle inputs: a finished command (and whether it asked for an interrupt), the end of the action list, a suspend request, a received frame, and running out of receive buffers. The four latched causes are combined into `irq`, which the host gates with `irq_enable`. The host clears causes through acknowledge bits. These bits travel in the same command word that issues new unit operations.

Top module: `ctl_cmd_status`

## Requirements
- R1: After reset, `status_word` is 0 and `irq` is 0.
- R2: The command-unit operation is in `host_cmd[10:8]` and takes effect on a `chan_attn` cycle. The codes are: 1 start, which gives active from any state; 3 suspend, which gives suspended if the unit was active; 4 abort, which gives idle. Codes 0, 5, 6 and 7 change nothing. The command-unit state appears in `status_word[10:8]` as 0 idle, 1 suspended, 2 active.
- R3: Command-unit resume (code 2) moves the unit from suspended to active. Receive-unit resume moves the unit from suspended to ready. In any other state, resume leaves the state unchanged.
- R4: The receive-unit operation is in `host_cmd[6:4]`, using the same codes as R2. Start gives ready. Suspend gives suspended only from ready. Abort gives idle. The receive-unit state appears in `status_word[6:4]` as 0 idle, 1 suspended, 2 no resources, 4 ready.
- R5: Engine events act only while the unit is active or ready, and only when no valid host operation (codes 1 to 4) targets that unit in the same cycle. `cu_end_of_list` gives idle, and otherwise `cu_hold` gives suspended. `ru_out_of_buffers` gives no resources, and otherwise `ru_hold` gives suspended.
- R6: `status_word[13]` (command unit not active) is set on every cycle in which the command unit leaves the active state.
- R7: `status_word[12]` (receive unit not ready) is set on every cycle in which the receive unit leaves the ready state.
- R8: `status_word[15]` is set when `cu_done` and `cu_done_int` are both high while the command unit is active. `status_word[14]` is set when `ru_frame_done` is high while the receive unit is ready.
- R9: On a `chan_attn` cycle, `host_cmd[15:12]` clears `status_word[15:12]` bit for bit. A cause that is set in that same cycle stays set.
- R10: `irq` is high exactly when `irq_enable` is high and at least one of `status_word[15:12]` is set. It follows `irq_enable` in the same cycle.
- R11: `status_word` bits 11, 7 and 3:0 always read 0.
- R12: With `chan_attn` low, `host_cmd` has no effect on unit states or causes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_cmd | input | 16 | Command word from the host |
| chan_attn | input | 1 | Strobe that applies `host_cmd` |
| irq_enable | input | 1 | Host gate for the interrupt output |
| cu_done | input | 1 | Command unit finished one command |
| cu_done_int | input | 1 | The finished command had its interrupt bit set |
| cu_end_of_list | input | 1 | Command unit reached the last list entry |
| cu_hold | input | 1 | Finished command requested a suspend |
| ru_frame_done | input | 1 | Receive unit completed a frame |
| ru_out_of_buffers | input | 1 | Receive unit ran out of buffers |
| ru_hold | input | 1 | Receive descriptor requested a suspend |
| status_word | output | 16 | Causes, unit states, reserved zeros |
| irq | output | 1 | Interrupt request |

## Verification
Several rules are checked on every cycle by assertions in the RTL:
- abort forces the command unit to idle;
- resume outside the suspended state leaves the command-unit state unchanged;
- leaving the active state latches the not-active cause;
- an acknowledge with no competing event clears the command-complete cause;
- running out of buffers while ready, with no host operation, moves the receive unit to no resources.

Other behaviour is shown only by the bench's scenarios, which compare the status word against a reference model over long random runs. This covers the priority of a host operation over an engine event in the same cycle, an event that arrives together with its own acknowledge, the reserved operation codes, and command words that arrive without the strobe.

// File: rtl/ctl_cmd_status.sv
module ctl_cmd_status (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] host_cmd,
  input  logic        chan_attn,
  input  logic        irq_enable,
  input  logic        cu_done,
  input  logic        cu_done_int,
  input  logic        cu_end_of_list,
  input  logic        cu_hold,
  input  logic        ru_frame_done,
  input  logic        ru_out_of_buffers,
  input  logic        ru_hold,
  output logic [15:0] status_word,
  output logic        irq
);

  localparam logic [2:0] OP_START   = 3'd1;
  localparam logic [2:0] OP_RESUME  = 3'd2;
  localparam logic [2:0] OP_SUSPEND = 3'd3;
  localparam logic [2:0] OP_ABORT   = 3'd4;

  localparam logic [2:0] CU_IDLE = 3'd0;
  localparam logic [2:0] CU_SUSP = 3'd1;
  localparam logic [2:0] CU_ACT  = 3'd2;

  localparam logic [2:0] RU_IDLE  = 3'd0;
  localparam logic [2:0] RU_SUSP  = 3'd1;
  localparam logic [2:0] RU_NORES = 3'd2;
  localparam logic [2:0] RU_READY = 3'd4;

  logic [2:0] cu_q, cu_nxt, ru_q, ru_nxt;
  logic [3:0] cause_q, cause_nxt, cause_set;

  wire [2:0] cu_op  = host_cmd[10:8];
  wire [2:0] ru_op  = host_cmd[6:4];
  wire [3:0] ack    = chan_attn ? host_cmd[15:12] : 4'd0;
  wire       cu_cmd = chan_attn && cu_op >= OP_START && cu_op <= OP_ABORT;
  wire       ru_cmd = chan_attn && ru_op >= OP_START && ru_op <= OP_ABORT;

  always_comb begin
    cu_nxt = cu_q;
    if (cu_cmd) begin
      case (cu_op)
        OP_START:   cu_nxt = CU_ACT;
        OP_RESUME:  if (cu_q == CU_SUSP) cu_nxt = CU_ACT;
        OP_SUSPEND: if (cu_q == CU_ACT) cu_nxt = CU_SUSP;
        default:    cu_nxt = CU_IDLE;
      endcase
    end else if (cu_q == CU_ACT) begin
      if (cu_end_of_list)  cu_nxt = CU_IDLE;
      else if (cu_hold)    cu_nxt = CU_SUSP;
    end
  end

  always_comb begin
    ru_nxt = ru_q;
    if (ru_cmd) begin
      case (ru_op)
        OP_START:   ru_nxt = RU_READY;
        OP_RESUME:  if (ru_q == RU_SUSP) ru_nxt = RU_READY;
        OP_SUSPEND: if (ru_q == RU_READY) ru_nxt = RU_SUSP;
        default:    ru_nxt = RU_IDLE;
      endcase
    end else if (ru_q == RU_READY) begin
      if (ru_out_of_buffers) ru_nxt = RU_NORES;
      else if (ru_hold)      ru_nxt = RU_SUSP;
    end
  end

  assign cause_set = {cu_q == CU_ACT && cu_done && cu_done_int,
                      ru_q == RU_READY && ru_frame_done,
                      cu_q == CU_ACT && cu_nxt != CU_ACT,
                      ru_q == RU_READY && ru_nxt != RU_READY};
  assign cause_nxt = (cause_q & ~ack) | cause_set;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cu_q    <= CU_IDLE;
      ru_q    <= RU_IDLE;
      cause_q <= 4'd0;
    end else begin
      cu_q    <= cu_nxt;
      ru_q    <= ru_nxt;
      cause_q <= cause_nxt;
    end
  end

  assign status_word = {cause_q, 1'b0, cu_q, 1'b0, ru_q, 4'b0000};
  assign irq         = irq_enable && (cause_q != 4'd0);

  assert_cu_abort_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_attn && host_cmd[10:8] == 3'd4) |=> status_word[10:8] == 3'd0);

  assert_resume_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_attn && host_cmd[10:8] == 3'd2 && status_word[10:8] != 3'd1)
      |=> $stable(status_word[10:8]));

  assert_cna_on_leave_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(status_word[10:8]) == 3'd2 && status_word[10:8] != 3'd2)
      |-> status_word[13]);

  assert_ack_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_attn && host_cmd[15] && !(cu_done && cu_done_int)) |=> !status_word[15]);

  assert_no_space_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!chan_attn && status_word[6:4] == 3'd4 && ru_out_of_buffers)
      |=> status_word[6:4] == 3'd2);

endmodule

// File: tb/ctl_cmd_status_tb_top.sv
`timescale 1ns/1ps
module ctl_cmd_status_tb_top;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [15:0] host_cmd = 0;
  logic        chan_attn = 0, irq_enable = 0;
  logic        cu_done = 0, cu_done_int = 0, cu_end_of_list = 0, cu_hold = 0;
  logic        ru_frame_done = 0, ru_out_of_buffers = 0, ru_hold = 0;
  logic [15:0] status_word;
  logic        irq;

  int vectors = 0, errors = 0;
  logic [2:0] m_cu = 0, m_ru = 0;
  logic [3:0] m_cause = 0;

  always #2 clk = ~clk;

  ctl_cmd_status dut_i (
    .clk(clk), .rst_n(rst_n), .host_cmd(host_cmd), .chan_attn(chan_attn),
    .irq_enable(irq_enable), .cu_done(cu_done), .cu_done_int(cu_done_int),
    .cu_end_of_list(cu_end_of_list), .cu_hold(cu_hold),
    .ru_frame_done(ru_frame_done), .ru_out_of_buffers(ru_out_of_buffers),
    .ru_hold(ru_hold), .status_word(status_word), .irq(irq));

  function automatic logic [2:0] cu_model(logic [2:0] s);
    logic [2:0] op = host_cmd[10:8];
    if (chan_attn && op >= 1 && op <= 4) begin
      if (op == 1) return 3'd2;
      if (op == 2) return (s == 3'd1) ? 3'd2 : s;
      if (op == 3) return (s == 3'd2) ? 3'd1 : s;
      return 3'd0;
    end
    if (s == 3'd2 && cu_end_of_list) return 3'd0;
    if (s == 3'd2 && cu_hold) return 3'd1;
    return s;
  endfunction

  function automatic logic [2:0] ru_model(logic [2:0] s);
    logic [2:0] op = host_cmd[6:4];
    if (chan_attn && op >= 1 && op <= 4) begin
      if (op == 1) return 3'd4;
      if (op == 2) return (s == 3'd1) ? 3'd4 : s;
      if (op == 3) return (s == 3'd4) ? 3'd1 : s;
      return 3'd0;
    end
    if (s == 3'd4 && ru_out_of_buffers) return 3'd2;
    if (s == 3'd4 && ru_hold) return 3'd1;
    return s;
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    logic [2:0] ncu, nru;
    logic [3:0] set, ack;
    @(posedge clk);
    #1;
    ncu = cu_model(m_cu);
    nru = ru_model(m_ru);
    set = {m_cu == 3'd2 && cu_done && cu_done_int, m_ru == 3'd4 && ru_frame_done,
           m_cu == 3'd2 && ncu != 3'd2, m_ru == 3'd4 && nru != 3'd4};
    ack = chan_attn ? host_cmd[15:12] : 4'd0;
    m_cause = (m_cause & ~ack) | set;
    m_cu = ncu;
    m_ru = nru;
    check("R2 cu state", {13'd0, status_word[10:8]}, {13'd0, m_cu});
    check("R4 ru state", {13'd0, status_word[6:4]}, {13'd0, m_ru});
    check("R9 causes", {12'd0, status_word[15:12]}, {12'd0, m_cause});
    check("R11 reserved", status_word & 16'h088F, 16'd0);
    check("R10 irq", {15'd0, irq}, {15'd0, irq_enable && m_cause != 0});
  endtask

  task automatic drive(logic attn, logic [15:0] cmd, logic [6:0] ev);
    chan_attn = attn; host_cmd = cmd;
    {cu_done, cu_done_int, cu_end_of_list, cu_hold,
     ru_frame_done, ru_out_of_buffers, ru_hold} = ev;
    step();
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234_5678));
    irq_enable = 1;
    @(posedge clk); @(posedge clk); #1;
    check("R1 reset status", status_word, 16'd0);
    check("R1 reset irq", {15'd0, irq}, 16'd0);
    rst_n = 1;
    // R3: resume on idle units is ignored
    drive(1, 16'h0220, 7'd0);
    // R12: start without strobe has no effect
    drive(0, 16'h0110, 7'd0);
    // R2/R4: start both units
    drive(1, 16'h0110, 7'd0);
    // R8: command complete and frame received
    drive(0, 16'h0000, 7'b1100100);
    // R5: host suspend beats end-of-list in the same cycle; RU runs out of buffers (R7)
    drive(1, 16'h0300, 7'b0010010);
    // R3: resume from suspended to active
    drive(1, 16'h0200, 7'd0);
    // R9: ack of command complete together with a new one keeps it set
    drive(1, 16'h8000, 7'b1100000);
    // R6: end of list drives command unit idle
    drive(0, 16'h0000, 7'b0010000);
    // R12: acks without strobe do nothing
    drive(0, 16'hF000, 7'd0);
    // R10: gate off
    irq_enable = 0;
    drive(1, 16'h7000, 7'd0);
    drive(1, 16'h8000, 7'd0);
    // R2: reserved code 5 leaves state
    drive(1, 16'h0510, 7'd0);
    drive(1, 16'h0400, 7'd0);
    for (int i = 0; i < 6000; i++) begin
      logic [15:0] c;
      logic [6:0] ev;
      irq_enable = ($urandom % 8) != 0;
      c = $urandom;
      c[11] = 0; c[7] = 0; c[3:0] = 0;
      if ($urandom % 3 != 0) c[10:8] = $urandom % 5;
      if ($urandom % 3 != 0) c[6:4] = $urandom % 5;
      for (int k = 0; k < 7; k++) ev[k] = ($urandom % 5) == 0;
      drive(($urandom % 3) == 0, c, ev);
    end
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule